// File: doc/BRIEF.md
# Power-Up Line Frequency Boot Selector

This block watches one control line for a fixed time after reset and decides, once, which boot path the chip takes. The line passes through a synchronizer. The block then measures the spacing of its rising edges in system-clock cycles. Silence, a fast square wave, a slow square wave or anything else each lead to a distinct boot action.

The measurement uses a saturating period counter. A band is accepted only after several consecutive periods land inside the same band's inclusive cycle limits. These limits are derived from the clock frequency and the band edges. The decision is taken when that condition is met or when the detection window closes, whichever happens first.

The decision is combined with two status inputs, user application installed and test application installed. It is held on five one-hot action outputs, with a one-cycle done pulse. The error paths also raise a sleep output. Only reset releases the held decision and the sleep output.

Top module: `pwrup_mode_sel`

## Requirements
- R1: With the default 50 MHz clock, a period of 25 to 62 cycles inclusive (2 MHz down to 800 kHz) counts as the fast band. Four consecutive fast periods raise `act_officer_auth`, and the decision comes before the window closes, whatever the status inputs are.
- R2: A period of 2000 to 10000 cycles inclusive (25 kHz down to 5 kHz) counts as the slow band. Four consecutive slow periods with `test_app_present` high raise `act_run_test`.
- R3: Four consecutive slow periods with `test_app_present` low raise `act_error` and `sleep_o`.
- R4: If no rising edge is seen before the window of WINDOW_US microseconds closes, the decision is made at window close, within one cycle of WINDOW_CYC clock cycles after reset release. It raises `act_run_app` when `app_present` is high and `act_user_auth` when it is low.
- R5: If edges were seen but no band qualified by window close, the block raises `act_error` and `sleep_o`. This covers periods just outside either band, such as 24 or 63 cycles.
- R6: A band needs RUN_LEN (4) consecutive in-band periods. A period outside both bands restarts the run. Three in-band periods followed by silence end as an error.
- R7: Before the decision no action output is high. At the decision exactly one action output rises, together with a single one-cycle `decide_done` pulse.
- R8: After the decision, the action outputs and `sleep_o` hold their values and further line activity has no effect. No second `decide_done` pulse occurs until reset.
- R9: While `rst_n` is low, all outputs are low. This includes a sleep state left over from an earlier decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Asynchronous control line to classify |
| app_present | input | 1 | A user application is installed |
| test_app_present | input | 1 | A test application is installed |
| act_officer_auth | output | 1 | Fast band seen: start officer authentication |
| act_user_auth | output | 1 | Silence, no application: start user authentication |
| act_run_app | output | 1 | Silence, application installed: run it |
| act_run_test | output | 1 | Slow band with test application: run it |
| act_error | output | 1 | Invalid pattern or missing test application |
| decide_done | output | 1 | One-cycle pulse when the decision is made |
| sleep_o | output | 1 | Sticky sleep state, cleared only by reset |

## Verification
The bench drives periods exactly on both edges of the fast band and just outside them. A comparator with an off-by-one limit would report an error for an in-band edge, or accept 24 or 63 cycles. A broken-run pattern and a pattern that stops after three good periods target the consecutive count. A design that accepts too few periods, or fails to restart its run, decides early or picks the officer path. Silent cases check the decision cycle against the window length. The line keeps toggling after every decision, which exposes a design that re-decides, pulses done twice or lets sleep drop without reset.

// File: rtl/pms_pkg.sv
// Shared types for the power-up line frequency boot selector.
// Assumes: bands are disjoint in period space.
package pms_pkg;
    typedef enum logic [1:0] {BAND_NONE, BAND_HIGH, BAND_LOW} band_e;
    typedef enum logic [1:0] {OUT_IDLE, OUT_RELOAD, OUT_TEST, OUT_BAD} outcome_e;
    typedef struct packed {
        logic officer;
        logic user;
        logic run_app;
        logic run_test;
        logic err;
    } action_t;

    function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/pms_edge_sync.sv
// Synchronizes an asynchronous line and flags its rising edges.
// Assumes: STAGES >= 2; rise_o is a single-cycle pulse per synchronized edge.
module pms_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    // Shift the line through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pms_period_meter.sv
// Counts clock cycles between consecutive rising edges with a saturating counter.
// Assumes: the first edge only arms the meter; later edges each report one period.
module pms_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             period_vld_o,
    output logic [CNT_W-1:0] period_o,
    output logic             seen_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Restart the count at each edge, otherwise count up and stick at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (rise_i) begin
            cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
            armed_q <= 1'b1;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign period_vld_o = rise_i & armed_q;
    assign period_o     = cnt_q;
    assign seen_o       = armed_q;

    // R5: a long gap must never wrap back into a band.
    a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !rise_i) |=> cnt_q == CNT_MAX);
    a_r5_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seen_o |=> seen_o);
endmodule

// File: rtl/pms_band_judge.sv
// Classifies each measured period into a band and tracks a run of equal bands.
// Assumes: inclusive cycle limits derived from CLK_HZ and the band edges; bands disjoint.
module pms_band_judge
    import pms_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned HI_MIN_HZ = 800_000,
    parameter int unsigned HI_MAX_HZ = 2_000_000,
    parameter int unsigned LO_MIN_HZ = 5_000,
    parameter int unsigned LO_MAX_HZ = 25_000,
    parameter int          RUN_LEN   = 4,
    parameter int          CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_vld_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             qual_o,
    output band_e            band_o
);
    localparam int          NB        = 2;
    localparam int unsigned HI_P_MIN  = ceil_div(CLK_HZ, HI_MAX_HZ);
    localparam int unsigned HI_P_MAX  = CLK_HZ / HI_MIN_HZ;
    localparam int unsigned LO_P_MIN  = ceil_div(CLK_HZ, LO_MAX_HZ);
    localparam int unsigned LO_P_MAX  = CLK_HZ / LO_MIN_HZ;
    localparam int          RW        = $clog2(RUN_LEN + 1);

    logic [NB-1:0] hit;
    band_e         cur_band;
    band_e         last_q;
    logic [RW-1:0] run_q;

    // One inclusive window comparator per band (index 0 fast, 1 slow).
    for (genvar b = 0; b < NB; b++) begin : g_band
        localparam int unsigned PMIN = (b == 0) ? HI_P_MIN : LO_P_MIN;
        localparam int unsigned PMAX = (b == 0) ? HI_P_MAX : LO_P_MAX;
        assign hit[b] = (32'(period_i) >= PMIN) && (32'(period_i) <= PMAX);
    end

    // Map comparator hits to a band label.
    always_comb begin
        if (hit[0])      cur_band = BAND_HIGH;
        else if (hit[1]) cur_band = BAND_LOW;
        else             cur_band = BAND_NONE;
    end

    // Extend, restart or clear the run of equal-band periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= BAND_NONE;
        end else if (period_vld_i) begin
            if (cur_band == BAND_NONE) begin
                run_q  <= '0;
                last_q <= BAND_NONE;
            end else if (cur_band == last_q) begin
                if (run_q != RW'(RUN_LEN)) run_q <= run_q + 1'b1;
            end else begin
                run_q  <= {{(RW-1){1'b0}}, 1'b1};
                last_q <= cur_band;
            end
        end
    end

    assign qual_o = (run_q == RW'(RUN_LEN));
    assign band_o = last_q;

    a_r6_qual_has_band: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> band_o != BAND_NONE);
    a_r6_run_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int'(run_q) <= int'($past(run_q)) + 1);
endmodule

// File: rtl/pms_boot_fsm.sv
// Takes the single boot decision from the band result, the window and the status inputs.
// Assumes: decision once per reset; actions and sleep are held until reset.
module pms_boot_fsm
    import pms_pkg::*;
#(
    parameter int WINDOW_CYC = 50_000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    qual_i,
    input  band_e   band_i,
    input  logic    seen_i,
    input  logic    app_i,
    input  logic    tapp_i,
    output action_t act_o,
    output logic    done_o,
    output logic    sleep_o
);
    localparam int CW = $clog2(WINDOW_CYC + 1);

    typedef enum logic {ST_WATCH, ST_HOLD} state_e;

    state_e   state_q;
    logic [CW-1:0] win_q;
    logic     decide;
    outcome_e outcome;
    action_t  nxt_act;
    action_t  act_q;
    logic     done_q;
    logic     sleep_q;

    // Decide on a qualified band, or on the last cycle of the window.
    always_comb begin
        decide = (state_q == ST_WATCH) && (qual_i || win_q == CW'(WINDOW_CYC - 1));
        if (qual_i)      outcome = (band_i == BAND_HIGH) ? OUT_RELOAD : OUT_TEST;
        else if (seen_i) outcome = OUT_BAD;
        else             outcome = OUT_IDLE;
    end

    // Turn the outcome and status inputs into one action.
    always_comb begin
        nxt_act = '0;
        unique case (outcome)
            OUT_RELOAD: nxt_act.officer = 1'b1;
            OUT_TEST:   if (tapp_i) nxt_act.run_test = 1'b1; else nxt_act.err = 1'b1;
            OUT_IDLE:   if (app_i)  nxt_act.run_app  = 1'b1; else nxt_act.user = 1'b1;
            default:    nxt_act.err = 1'b1;
        endcase
    end

    // Run the window, latch the decision once, then hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            win_q   <= '0;
            act_q   <= '0;
            done_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (decide) begin
                state_q <= ST_HOLD;
                act_q   <= nxt_act;
                done_q  <= 1'b1;
                sleep_q <= nxt_act.err;
            end else if (state_q == ST_WATCH) begin
                win_q   <= win_q + 1'b1;
            end
        end
    end

    assign act_o   = act_q;
    assign done_o  = done_q;
    assign sleep_o = sleep_q;

    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_o));
    a_r7_one_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones(act_o) == 1);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> ($stable(act_o) && !done_o));
    a_r8_sleep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> sleep_o);
    a_r3_sleep_with_error: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> act_o.err);
endmodule

// File: rtl/pwrup_mode_sel.sv
// Top of the power-up line frequency boot selector: synchronizer, period meter,
// band judge and boot decision. Assumes line_in is asynchronous to clk.
module pwrup_mode_sel
    import pms_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned WINDOW_US   = 1000,
    parameter int unsigned HI_MIN_HZ   = 800_000,
    parameter int unsigned HI_MAX_HZ   = 2_000_000,
    parameter int unsigned LO_MIN_HZ   = 5_000,
    parameter int unsigned LO_MAX_HZ   = 25_000,
    parameter int          RUN_LEN     = 4,
    parameter int          CNT_W       = 16,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic app_present,
    input  logic test_app_present,
    output logic act_officer_auth,
    output logic act_user_auth,
    output logic act_run_app,
    output logic act_run_test,
    output logic act_error,
    output logic decide_done,
    output logic sleep_o
);
    localparam int WINDOW_CYC = int'((CLK_HZ / 1_000_000) * WINDOW_US);

    logic             rise;
    logic             period_vld;
    logic [CNT_W-1:0] period;
    logic             seen;
    logic             qual;
    band_e            band;
    action_t          act;

    pms_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(line_in), .rise_o(rise)
    );

    pms_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .rise_i(rise),
        .period_vld_o(period_vld), .period_o(period), .seen_o(seen)
    );

    pms_band_judge #(
        .CLK_HZ(CLK_HZ), .HI_MIN_HZ(HI_MIN_HZ), .HI_MAX_HZ(HI_MAX_HZ),
        .LO_MIN_HZ(LO_MIN_HZ), .LO_MAX_HZ(LO_MAX_HZ),
        .RUN_LEN(RUN_LEN), .CNT_W(CNT_W)
    ) u_judge (
        .clk(clk), .rst_n(rst_n), .period_vld_i(period_vld), .period_i(period),
        .qual_o(qual), .band_o(band)
    );

    pms_boot_fsm #(.WINDOW_CYC(WINDOW_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .qual_i(qual), .band_i(band), .seen_i(seen),
        .app_i(app_present), .tapp_i(test_app_present),
        .act_o(act), .done_o(decide_done), .sleep_o(sleep_o)
    );

    assign act_officer_auth = act.officer;
    assign act_user_auth    = act.user;
    assign act_run_app      = act.run_app;
    assign act_run_test     = act.run_test;
    assign act_error        = act.err;
endmodule

// File: tb/pwrup_mode_sel_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module pwrup_mode_sel_bench;
    localparam int WIN_US = 200;
    localparam int WIN    = 50 * WIN_US;   // cycles at the default 50 MHz rating

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic app = 1'b0;
    logic tapp = 1'b0;
    logic officer, user, run_app, run_test, err, done, sleep;

    int n_chk = 0;
    int n_fail = 0;
    bit stop_gen;
    bit got_done;
    int done_at;
    logic [4:0] act_seen;
    logic       sleep_seen;

    always #2 clk = ~clk;

    pwrup_mode_sel #(.WINDOW_US(WIN_US)) u_pwrup_mode_sel (
        .clk(clk), .rst_n(rst_n), .line_in(line), .app_present(app),
        .test_app_present(tapp), .act_officer_auth(officer), .act_user_auth(user),
        .act_run_app(run_app), .act_run_test(run_test), .act_error(err),
        .decide_done(done), .sleep_o(sleep)
    );

    function automatic logic [4:0] acts();
        return {officer, user, run_app, run_test, err};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Hold reset, set status inputs, check the reset state (R9), then release.
    task automatic do_reset(input logic a, input logic t);
        @(negedge clk);
        rst_n = 1'b0; line = 1'b0; app = a; tapp = t;
        repeat (4) @(negedge clk);
        check({acts(), done, sleep} == 7'b0, "R9", "outputs in reset",
              int'({acts(), done, sleep}), 0);
        rst_n = 1'b1;
    endtask

    // n1 periods of p1, n2 of p2, then p3 until stopped (period 0 = line low).
    task automatic gen_line(input int p1, input int n1, input int p2, input int n2,
                            input int p3);
        int ph = 0;
        int idx = 0;
        int p;
        while (!stop_gen) begin
            p = (idx < n1) ? p1 : (idx < n1 + n2) ? p2 : p3;
            line = (p != 0) && (ph < p / 2);
            @(negedge clk);
            ph++;
            if (p != 0 && ph >= p) begin ph = 0; idx++; end
        end
        line = 1'b0;
    endtask

    // Wait for done, record actions, then watch the held state with the line active.
    task automatic watch(input string req, input logic [4:0] exp_act, input logic exp_sleep);
        got_done = 1'b0;
        done_at = 0;
        for (int i = 1; i <= WIN + 100; i++) begin
            @(negedge clk);
            if (done) begin got_done = 1'b1; done_at = i; break; end
            if (acts() != 5'b0) begin
                check(1'b0, "R7", "action before decision", int'(acts()), 0);
                break;
            end
        end
        check(got_done, "R7", "decision pulse seen", int'(got_done), 1);
        act_seen = acts();
        sleep_seen = sleep;
        check(act_seen == exp_act, req, "action vector", int'(act_seen), int'(exp_act));
        check(sleep_seen == exp_sleep, req, "sleep", int'(sleep_seen), int'(exp_sleep));
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done || acts() != act_seen || sleep != sleep_seen) begin
                check(1'b0, "R8", "held decision changed", int'({acts(), done, sleep}),
                      int'({act_seen, 1'b0, sleep_seen}));
                break;
            end
        end
        check(1'b1, "R8", "decision held", 0, 0);
        stop_gen = 1'b1;
    endtask

    task automatic run_case(input string req, input logic a, input logic t,
                            input int p1, input int n1, input int p2, input int n2,
                            input int p3, input logic [4:0] exp_act, input logic exp_sleep);
        stop_gen = 1'b0;
        do_reset(a, t);
        fork
            gen_line(p1, n1, p2, n2, p3);
            watch(req, exp_act, exp_sleep);
        join
    endtask

    // Scenario: silence with and without an installed application (R4).
    task automatic t_idle(input logic a);
        run_case("R4", a, 1'b1, 0, 0, 0, 0, 0, a ? 5'b00100 : 5'b01000, 1'b0);
        check(done_at >= WIN - 1 && done_at <= WIN + 1, "R4", "window close cycle",
              done_at, WIN);
    endtask

    // Scenario: fast band, decided early, regardless of status inputs (R1).
    task automatic t_fast(input int p);
        run_case("R1", 1'b1, 1'b1, p, 0, 0, 0, p, 5'b10000, 1'b0);
        check(done_at < WIN, "R1", "decided before window close", done_at, WIN);
    endtask

    // Scenario: slow band with test application (R2) or without it (R3).
    task automatic t_slow(input logic t);
        if (t) run_case("R2", 1'b0, 1'b1, 2000, 0, 0, 0, 2000, 5'b00010, 1'b0);
        else   run_case("R3", 1'b1, 1'b0, 2000, 0, 0, 0, 2000, 5'b00001, 1'b1);
    endtask

    // Scenario: periods just outside the fast band are invalid (R5).
    task automatic t_bad(input int p);
        run_case("R5", 1'b1, 1'b1, p, 0, 0, 0, p, 5'b00001, 1'b1);
    endtask

    // Scenario: a run broken by an out-of-band period restarts (R6).
    task automatic t_broken_run();
        run_case("R6", 1'b0, 1'b0, 50, 3, 300, 1, 50, 5'b10000, 1'b0);
        check(done_at >= 650, "R6", "run restarted after break", done_at, 650);
    endtask

    // Scenario: only three good periods, then silence (R6).
    task automatic t_short_run();
        run_case("R6", 1'b1, 1'b1, 50, 4, 0, 0, 0, 5'b00001, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_idle(1'b1);
        t_idle(1'b0);
        t_fast(50);
        t_fast(25);
        t_fast(62);
        t_bad(24);
        t_bad(63);
        t_slow(1'b1);
        t_slow(1'b0);
        t_broken_run();
        t_short_run();
        do_reset(1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule